// File: doc/BRIEF.md
# Double-Buffered DAC Code Register with Byte Assembly

This block is the processor-facing side of a 10-bit digital-to-analog converter. Data passes through two stages. The first stage is a staging latch split into an 8-bit upper part and a 2-bit lower part. The second stage is a 10-bit output register that drives the converter code. All inputs are strobes sampled on the rising edge of a system clock.

A host on a 10-bit bus writes a whole code in one cycle. A host on an 8-bit bus builds the code from two writes. The first write, in full mode, sets the upper eight bits. The second write, in lower mode, overwrites only the two low bits. The 8-bit bus sits on the upper lines of the data port, so the word stays left-justified.

The output register changes only on a transfer. A transfer requires lower mode, so a half-assembled word never reaches the output. Several instances can share one transfer strobe. Each instance is loaded on its own, and then all outputs switch on the same cycle.

Top module: `dac_dbuf_reg`

## Requirements
- R1: A synchronous active-high `rst` clears the staging latch, `code` and `upd` to zero. A transfer issued right after reset therefore presents code 0.
- R2: The staging latch changes only on a cycle where both `cs_n` and `wr_n` are 0. Any other combination leaves it unchanged. This is visible through a later transfer.
- R3: A write with `full_sel`=1 loads `din[9:0]` into the staging latch. Bit 9 is the MSB and bit 0 is the LSB.
- R4: A write with `full_sel`=0 loads `din[9:8]` (the top two lines of the 8-bit bus on `din[9:2]`) into latch bits 1:0. Latch bits 9:2 are left unchanged.
- R5: A transfer happens on a cycle where `xfer_n`=0, `wr_n`=0 and `full_sel`=0, regardless of `cs_n`. After that rising edge, `code` equals the staging latch.
- R6: With `full_sel`=1, `xfer_n`=0 has no effect on `code`. With `wr_n`=1, `xfer_n`=0 also has no effect on `code`.
- R7: On every cycle without a transfer, `code` holds its value, even while the staging latch is being rewritten.
- R8: When a write and a transfer occur in the same cycle, `code` receives the latch value from before that write. The new data appears only after a later transfer.
- R9: `upd` is 1 for exactly the one cycle that follows each transfer edge, which is the cycle in which `code` first shows the new value. Otherwise `upd` is 0.
- R10: Two instances with separate `cs_n` and a shared `xfer_n` each hold their own staged code. Both update on the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low, qualifies writes |
| wr_n | input | 1 | Write strobe, active low |
| full_sel | input | 1 | 1: write all ten bits; 0: write low two bits, enable transfer |
| xfer_n | input | 1 | Transfer strobe, active low |
| din | input | 10 | Data; 8-bit bytes on din[9:2] |
| code | output | 10 | DAC code held in the output register |
| upd | output | 1 | One-cycle pulse when `code` has just loaded |

## Verification
The bench sweeps every 10-bit word through full-mode writes. It also sweeps every upper-byte and lower-pair combination through two-byte assembly. This catches a design that takes the second byte from the wrong bus lines, because such a design would land the bits in the wrong positions. It also catches a design that clobbers the upper byte, which would corrupt the upper eight bits.

The bench issues transfers while full mode is selected and while `wr_n` is high. A design that ignores either qualifier would update `code` early.

It makes a write and a transfer coincide. A design that forwards the write data into the transfer would show the new word one transfer too soon.

Two instances share one transfer strobe. This exposes a design that depends on chip select for the transfer, since such a design would leave the deselected instance stale.

// File: rtl/dac_dbuf_reg.sv
module dac_dbuf_reg #(
  parameter int CODE_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              full_sel,
  input  logic              xfer_n,
  input  logic [CODE_W-1:0] din,
  output logic [CODE_W-1:0] code,
  output logic              upd
);
  localparam int LO_W = CODE_W - BYTE_W;

  logic [BYTE_W-1:0] hi_q;
  logic [LO_W-1:0]   lo_q;
  logic              wr_en;
  logic              xfer_en;

  assign wr_en   = !cs_n && !wr_n;
  assign xfer_en = !xfer_n && !wr_n && !full_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (wr_en) begin
      if (full_sel) begin
        hi_q <= din[CODE_W-1:LO_W];
        lo_q <= din[LO_W-1:0];
      end else begin
        lo_q <= din[CODE_W-1 -: LO_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= '0;
      upd  <= 1'b0;
    end else begin
      if (xfer_en) code <= {hi_q, lo_q};
      upd <= xfer_en;
    end
  end

  p_latch_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(hi_q) && $stable(lo_q)));

  p_upper_kept_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !full_sel) |=> $stable(hi_q));

  p_load_value_r5: assert property (@(posedge clk) disable iff (rst)
    xfer_en |=> (code == $past({hi_q, lo_q})));

  p_code_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !xfer_en |=> $stable(code));

  p_full_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    (full_sel || wr_n) |=> !upd);

  p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    xfer_en |=> upd);
endmodule

// File: tb/test_dac_dbuf_reg.sv
module test_dac_dbuf_reg;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_a_n = 1'b1, cs_b_n = 1'b1, wr_n = 1'b1, full_sel = 1'b1, xfer_n = 1'b1;
  logic [9:0] din = '0;
  logic [9:0] code_a, code_b;
  logic upd_a, upd_b;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] hi_e [2];
  logic [1:0] lo_e [2];
  logic [9:0] dac_e [2];
  logic       upd_e;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_dbuf_reg i_dac_dbuf_reg (
    .clk(clk), .rst(rst), .cs_n(cs_a_n), .wr_n(wr_n), .full_sel(full_sel),
    .xfer_n(xfer_n), .din(din), .code(code_a), .upd(upd_a));

  dac_dbuf_reg i_dac_dbuf_reg_b (
    .clk(clk), .rst(rst), .cs_n(cs_b_n), .wr_n(wr_n), .full_sel(full_sel),
    .xfer_n(xfer_n), .din(din), .code(code_b), .upd(upd_b));

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "code_a", int'(code_a), int'(dac_e[0]));
    check(tag, "code_b", int'(code_b), int'(dac_e[1]));
    check((tag == "R9") ? "R9" : {tag, "/R9"}, "upd_a", int'(upd_a), int'(upd_e));
    check((tag == "R9") ? "R9" : {tag, "/R9"}, "upd_b", int'(upd_b), int'(upd_e));
  endtask

  task automatic step(input logic sa, input logic sb, input logic w, input logic fs,
                      input logic xf, input logic [9:0] d, input string tag);
    logic fire;
    cs_a_n = sa; cs_b_n = sb; wr_n = w; full_sel = fs; xfer_n = xf; din = d;
    @(posedge clk);
    fire = !xf && !w && !fs;
    for (int k = 0; k < 2; k++) begin
      logic sel;
      sel = (k == 0) ? sa : sb;
      if (fire) dac_e[k] = {hi_e[k], lo_e[k]};
      if (!sel && !w) begin
        if (fs) begin
          hi_e[k] = d[9:2];
          lo_e[k] = d[1:0];
        end else begin
          lo_e[k] = d[9:8];
        end
      end
    end
    upd_e = fire;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1; cs_a_n = 1'b1; cs_b_n = 1'b1; wr_n = 1'b1; full_sel = 1'b1; xfer_n = 1'b1;
    @(posedge clk);
    for (int k = 0; k < 2; k++) begin
      hi_e[k] = '0; lo_e[k] = '0; dac_e[k] = '0;
    end
    upd_e = 1'b0;
    @(negedge clk);
    compare("R1");
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    step(1, 1, 0, 0, 0, 10'h000, "R1");

    // R3/R5: every word through full-mode write then transfer
    for (int w = 0; w < 1024; w++) begin
      step(0, 1, 0, 1, 1, 10'(w), "R3");
      step(1, 1, 0, 0, 0, 10'h000, "R5");
    end

    // R4: every upper byte with every lower pair, two-byte assembly
    for (int h = 0; h < 256; h++) begin
      for (int l = 0; l < 4; l++) begin
        step(0, 1, 0, 1, 1, {8'(h), 2'(3 - l)}, "R4");
        step(0, 1, 0, 0, 1, {2'(l), 8'(255 - h)}, "R4");
        step(1, 1, 0, 0, 0, 10'h000, "R4");
      end
    end

    // R2: writes without both strobes active are ignored
    step(0, 1, 0, 1, 1, 10'h155, "R2");
    step(1, 1, 0, 1, 1, 10'h2AA, "R2");
    step(0, 1, 1, 1, 1, 10'h3C3, "R2");
    step(0, 1, 1, 0, 1, 10'h300, "R2");
    step(1, 1, 0, 0, 0, 10'h000, "R2");

    // R6: transfer blocked by full mode or by write deasserted
    step(0, 1, 0, 1, 1, 10'h0F0, "R6");
    step(1, 1, 0, 1, 0, 10'h000, "R6");
    step(1, 1, 1, 0, 0, 10'h000, "R6");
    step(1, 1, 1, 1, 0, 10'h000, "R6");
    step(1, 1, 0, 0, 0, 10'h000, "R5");

    // R7: repeated staging without transfer leaves code alone
    for (int i = 0; i < 8; i++) step(0, 1, 0, i[0], 1, 10'(i * 97), "R7");

    // R8: write and transfer in the same cycle
    step(0, 1, 0, 1, 1, 10'h201, "R8");
    step(1, 1, 0, 0, 0, 10'h000, "R8");
    step(0, 1, 0, 0, 0, 10'h300, "R8");
    step(1, 1, 0, 0, 0, 10'h000, "R8");

    // R9: back-to-back transfers, then idle
    step(1, 1, 0, 0, 0, 10'h000, "R9");
    step(1, 1, 1, 1, 1, 10'h000, "R9");

    // R10: separate staging, shared transfer
    step(0, 1, 0, 1, 1, 10'h1A5, "R10");
    step(1, 0, 0, 1, 1, 10'h35A, "R10");
    step(1, 0, 0, 0, 1, 10'h100, "R10");
    step(1, 1, 0, 0, 0, 10'h000, "R10");

    // R1: reset clears a loaded latch
    step(0, 0, 0, 1, 1, 10'h3FF, "R1");
    do_reset();
    step(1, 1, 0, 0, 0, 10'h000, "R1");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule